// File: doc/BRIEF.md
# Multi-operand carry-save adder

This block adds K unsigned words of N bits each in one combinational pass. The operands are not summed pairwise. The block first folds them three at a time through a chain of K−2 carry-save rows. Each row is a set of independent full adders that turns three vectors into a sum vector and a carry vector, and the carry vector moves up one bit position before the next row. No carry crosses a bit boundary inside a row, so each row costs one full-adder delay whatever its width.

After the last row, two vectors remain: the sum and the carry. One ripple carry-propagate adder resolves them into the true binary total. The result is returned at full precision, N + ceil(log2 K) bits wide, so the total of K all-ones operands still fits. The operands arrive as a packed array, and word 0 sits in the least significant N bits.

The block has no clock, no state and no handshake. It suits a datapath that needs the total of several words in the same cycle, such as an accumulation tree or the partial-product summation of a multiplier.

Top module: `multi_operand_csa`

## Requirements
- R1: `total_o` equals the exact unsigned sum of all K words of `operands`, for any operand values.
- R2: `total_o` is N + ceil(log2 K) bits wide and loses nothing when every operand is all ones; with K=4 and N=4 that gives 60 (6'b111100).
- R3: With K=4 and N=4, the words 0001, 0111, 1101 and 0010 (word 0 first) give a total of 10111 (decimal 23).
- R4: Every operand position carries the same weight: a single nonzero word placed in any slot, with all other slots zero, appears unchanged at `total_o`.
- R5: Each carry-save row preserves value. Its sum vector plus its shifted carry vector equals the sum of its three input vectors, and the final adder's result equals the last row's sum plus carry.
- R6: Bit 0 of every shifted carry vector is zero; each row is one bit wider than its inputs.
- R7: The bits of the final carry-propagate result above the output width are always zero, so truncating to the output width drops no value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operands | input | K*N (packed [K-1:0][N-1:0]) | The K unsigned words to add; word i occupies bits [i*N +: N] |
| total_o | output | N + ceil(log2 K) | Full-precision unsigned sum of all words |

## Verification
The block holds no state, so a wrong carry-save row shows up at the ports as soon as the inputs change. The fault appears in `total_o` for the same input set, with no delay in cycles. A carry that is not shifted, or is shifted the wrong way, corrupts the total only when two or more bits of a column are set together. The bench therefore pairs dense patterns (all ones, three all-ones words, many random sets) with single-slot patterns, which expose a misplaced or missing operand. The internal checks fire at once on any row that does not conserve value and on any carry bit 0 that is not zero, before the error reaches the output.

// File: rtl/mocsa_pkg.sv
package mocsa_pkg;

    // Output width needed to hold the sum of k words of n bits without loss.
    function automatic int total_width(input int n, input int k);
        return n + $clog2(k);
    endfunction

    // Width of the final carry-propagate result for k words of n bits.
    function automatic int chain_width(input int n, input int k);
        return n + k - 1;
    endfunction

endpackage

// File: rtl/mocsa_fa_cell.sv
module mocsa_fa_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic co_o
);

    logic ab_x;

    always_comb begin
        ab_x = a_i ^ b_i;
        s_o  = ab_x ^ c_i;
        co_o = (a_i & b_i) | (ab_x & c_i);
    end

endmodule

// File: rtl/mocsa_csa_row.sv
// One carry-save row: W independent full adders. The sum result is
// zero-extended by one bit and the carry result is moved up one position,
// so both outputs are W+1 bits wide and can be summed directly.
module mocsa_csa_row #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    output logic [W:0]   sum_o,
    output logic [W:0]   carry_o
);

    logic [W-1:0] bit_sum;
    logic [W-1:0] bit_carry;

    for (genvar b = 0; b < W; b++) begin : g_bit
        mocsa_fa_cell u_fa (
            .a_i  (x_i[b]),
            .b_i  (y_i[b]),
            .c_i  (z_i[b]),
            .s_o  (bit_sum[b]),
            .co_o (bit_carry[b])
        );
    end

    assign sum_o   = {1'b0, bit_sum};
    assign carry_o = {bit_carry, 1'b0};

endmodule

// File: rtl/mocsa_ripple_cpa.sv
// Carry-propagate adder built as a ripple chain of full adders.
module mocsa_ripple_cpa #(
    parameter int W = 6
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W:0]   sum_o
);

    logic [W:0] chain;

    assign chain[0] = 1'b0;

    for (genvar b = 0; b < W; b++) begin : g_bit
        mocsa_fa_cell u_fa (
            .a_i  (a_i[b]),
            .b_i  (b_i[b]),
            .c_i  (chain[b]),
            .s_o  (sum_o[b]),
            .co_o (chain[b+1])
        );
    end

    assign sum_o[W] = chain[W];

endmodule

// File: rtl/multi_operand_csa.sv
module multi_operand_csa
    import mocsa_pkg::*;
#(
    parameter int K = 4,
    parameter int N = 4
) (
    input  logic [K-1:0][N-1:0]              operands,
    output logic [total_width(N, K)-1:0]     total_o
);

    localparam int STAGES = K - 2;
    localparam int FULL_W = chain_width(N, K);
    localparam int OUT_W  = total_width(N, K);
    localparam int LAST_W = FULL_W - 1;

    // Zero-extended views of every row's inputs and outputs.
    logic [FULL_W-1:0] st_a [STAGES];
    logic [FULL_W-1:0] st_b [STAGES];
    logic [FULL_W-1:0] st_c [STAGES];
    logic [FULL_W-1:0] st_s [STAGES];
    logic [FULL_W-1:0] st_k [STAGES];
    logic [FULL_W-1:0] cpa_sum;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int IW = N + s;
        logic [IW-1:0] in_x;
        logic [IW-1:0] in_y;
        logic [IW-1:0] in_z;
        logic [IW:0]   o_sum;
        logic [IW:0]   o_carry;

        if (s == 0) begin : g_first
            assign in_x = operands[0];
            assign in_y = operands[1];
        end else begin : g_next
            assign in_x = st_s[s-1][IW-1:0];
            assign in_y = st_k[s-1][IW-1:0];
        end
        assign in_z = IW'(operands[s+2]);

        mocsa_csa_row #(.W(IW)) u_row (
            .x_i     (in_x),
            .y_i     (in_y),
            .z_i     (in_z),
            .sum_o   (o_sum),
            .carry_o (o_carry)
        );

        assign st_a[s] = FULL_W'(in_x);
        assign st_b[s] = FULL_W'(in_y);
        assign st_c[s] = FULL_W'(in_z);
        assign st_s[s] = FULL_W'(o_sum);
        assign st_k[s] = FULL_W'(o_carry);
    end

    mocsa_ripple_cpa #(.W(LAST_W)) u_cpa (
        .a_i   (st_s[STAGES-1][LAST_W-1:0]),
        .b_i   (st_k[STAGES-1][LAST_W-1:0]),
        .sum_o (cpa_sum)
    );

    assign total_o = cpa_sum[OUT_W-1:0];

endmodule

// File: rtl/multi_operand_csa_chk.sv
module multi_operand_csa_chk
    import mocsa_pkg::*;
#(
    parameter int K = 4,
    parameter int N = 4
) (
    input  logic [K-1:0][N-1:0]                  operands,
    input  logic [chain_width(N, K)-1:0]         st_a [K-2],
    input  logic [chain_width(N, K)-1:0]         st_b [K-2],
    input  logic [chain_width(N, K)-1:0]         st_c [K-2],
    input  logic [chain_width(N, K)-1:0]         st_s [K-2],
    input  logic [chain_width(N, K)-1:0]         st_k [K-2],
    input  logic [chain_width(N, K)-1:0]         cpa_sum,
    input  logic [total_width(N, K)-1:0]         total_o
);

    localparam int STAGES = K - 2;
    localparam int FULL_W = chain_width(N, K);
    localparam int OUT_W  = total_width(N, K);
    localparam int ACC_W  = FULL_W + 2;

    logic [ACC_W-1:0] ref_total;
    logic [ACC_W-1:0] lhs;
    logic [ACC_W-1:0] rhs;

    always_comb begin
        ref_total = '0;
        for (int i = 0; i < K; i++) begin
            ref_total = ref_total + ACC_W'(operands[i]);
        end
        AST_TOTAL_EXACT: assert (ACC_W'(total_o) == ref_total)
            else $error("total_o differs from operand sum"); // R1
        AST_TOP_BITS_CLEAR: assert ((cpa_sum >> OUT_W) == '0)
            else $error("final adder bits above output width set"); // R7
        AST_CPA_RESOLVES: assert (ACC_W'(cpa_sum) ==
                                  ACC_W'(st_s[STAGES-1]) + ACC_W'(st_k[STAGES-1]))
            else $error("final adder result wrong"); // R5
        for (int s = 0; s < STAGES; s++) begin
            lhs = ACC_W'(st_s[s]) + ACC_W'(st_k[s]);
            rhs = ACC_W'(st_a[s]) + ACC_W'(st_b[s]) + ACC_W'(st_c[s]);
            AST_STAGE_KEEPS_VALUE: assert (lhs == rhs)
                else $error("carry-save row %0d lost value", s); // R5
            AST_CARRY_LSB_ZERO: assert (st_k[s][0] == 1'b0)
                else $error("carry vector of row %0d has bit 0 set", s); // R6
        end
    end

endmodule

bind multi_operand_csa multi_operand_csa_chk #(.K(K), .N(N)) u_chk (
    .operands (operands),
    .st_a     (st_a),
    .st_b     (st_b),
    .st_c     (st_c),
    .st_s     (st_s),
    .st_k     (st_k),
    .cpa_sum  (cpa_sum),
    .total_o  (total_o)
);

// File: tb/multi_operand_csa_test.sv
`timescale 1ns/1ps
module multi_operand_csa_test;

    localparam int K = 4;
    localparam int N = 4;
    localparam int OUT_W = N + $clog2(K);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [K-1:0][N-1:0] operands = '0;
    logic [OUT_W-1:0] total_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    multi_operand_csa #(.K(K), .N(N)) uut (
        .operands (operands),
        .total_o  (total_o)
    );

    task automatic check(input string req, input int expv);
        checks++;
        if (int'(total_o) != expv) begin
            errors++;
            $display("FAIL %s: total_o=%0d expected=%0d", req, total_o, expv);
        end
    endtask

    // Drive away from the clock edge, let the combinational path settle,
    // then compare with an independently computed sum.
    task automatic apply_and_check(input string req, input logic [K-1:0][N-1:0] ops);
        int e = 0;
        @(negedge clk);
        operands = ops;
        #1;
        for (int i = 0; i < K; i++) e += int'(ops[i]);
        check(req, e);
    endtask

    task automatic t_reset;
        #1;
        check("R1", 0);  // zero inputs during reset give zero
    endtask

    task automatic t_example;
        logic [K-1:0][N-1:0] ops;
        ops[0] = 4'b0001; ops[1] = 4'b0111; ops[2] = 4'b1101; ops[3] = 4'b0010;
        @(negedge clk);
        operands = ops;
        #1;
        check("R3", 23);   // 10111
        check("R5", 23);   // rows conserve value along the way
    endtask

    task automatic t_all_ones;
        @(negedge clk);
        operands = '1;
        #1;
        check("R2", 60);   // 6'b111100
        check("R7", 60);   // no value above output width
    endtask

    task automatic t_slots;
        for (int i = 0; i < K; i++) begin
            logic [K-1:0][N-1:0] ops = '0;
            ops[i] = 4'b1001;
            apply_and_check("R4", ops);
        end
    endtask

    task automatic t_dense;
        logic [K-1:0][N-1:0] ops;
        ops[0] = 4'hF; ops[1] = 4'hF; ops[2] = 4'hF; ops[3] = 4'h0;
        apply_and_check("R6", ops);  // three ones per column: carry must shift up
        ops[0] = 4'h1; ops[1] = 4'h1; ops[2] = 4'h1; ops[3] = 4'h1;
        apply_and_check("R6", ops);
        ops[0] = 4'h0; ops[1] = 4'hF; ops[2] = 4'hF; ops[3] = 4'hF;
        apply_and_check("R1", ops);
    endtask

    task automatic t_random;
        for (int n = 0; n < 60; n++) begin
            logic [K-1:0][N-1:0] ops;
            for (int i = 0; i < K; i++) ops[i] = N'($urandom);
            if (n % 5 == 0) ops[n % K] = '1;
            apply_and_check("R1", ops);
        end
    endtask

    initial begin
        t_reset();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_example();
        t_all_ones();
        t_slots();
        t_dense();
        t_random();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule